// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block turns a fast peripheral clock into the bit timing of an I2C controller. A prescaler divides the peripheral clock by (1 + CDF) and produces a one-cycle internal tick. A phase sequencer counts those ticks to build SCL periods of 20 + 8·SCGD + R ticks. CDF and SCGD come from one packed configuration word. R is a rise/fall/internal-delay compensation count supplied on its own input.

Each period has a low half and a high half, and any odd tick goes to the low half. The sequencer drives a "pull SCL low" level and one-cycle strobes at the start of each phase, which a controller engine uses to shift data. High-phase ticks are counted only while the sampled SCL line is actually high. A target that stretches the clock therefore lengthens the period instead of shortening the high time.

While disabled, the block holds every counter at zero and leaves SCL released. Each enable starts a fresh low phase of full length. A generation parameter selects a 2-bit or a 3-bit CDF field. The CDF and SCGD values are meant to keep the internal tick below 20 MHz; the block does not compute them.

Top module: `scl_rate_gen`

## Requirements
- R1: During reset and while `en` is low, `tick`, `ph_low`, `ph_high` and `scl_low_o` are all 0 (SCL released).
- R2: While enabled, `tick` pulses for one cycle every 1 + CDF peripheral clock cycles.
- R3: The configuration word carries CDF in its low CDF_W bits and SCGD in the 6 bits directly above them. CDF_W is 3 when GEN is nonzero and 2 when GEN is 0.
- R4: With SCL not stretched, one SCL period (low run plus released run of `scl_low_o`) lasts (20 + 8·SCGD + R)·(1 + CDF) clock cycles.
- R5: The low phase lasts ceil(P/2) ticks and the high phase floor(P/2) ticks, where P = 20 + 8·SCGD + R.
- R6: `ph_low` pulses for one cycle in the first cycle of every low phase, including the first cycle after enable. `ph_high` pulses for one cycle in the first cycle of every high phase. The two strobes are never high together.
- R7: A high-phase tick counts only when `scl_in` is 1. Holding `scl_in` low for S cycles (S a multiple of 1 + CDF) lengthens the released run by exactly S cycles.
- R8: Dropping `en` in the middle of a period releases SCL and clears the counters in the next cycle. The next enable starts with a low phase of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider enable |
| cfg_word | input | CDF_W+6 | Packed SCGD (upper) and CDF (lower) fields |
| comp | input | RW | Rise/fall/delay compensation count R, in ticks |
| scl_in | input | 1 | Sampled SCL line level |
| tick | output | 1 | Internal clock enable pulse |
| ph_low | output | 1 | Strobe at start of low phase |
| ph_high | output | 1 | Strobe at start of high phase |
| scl_low_o | output | 1 | 1 = pull SCL low |

## Verification
The bench targets the odd-length period. A divider that rounded the wrong way would give the extra tick to the high half, and the measured low and released runs would each be off by one tick. It sets the top CDF bits against the lowest SCGD bit in both field widths. A field split at the wrong bit would then show up as a wrong tick spacing or a period 8 ticks off. It stretches SCL right after release and disables mid-period. A sequencer that counted ticks while SCL was held low would release early, and one that kept a stale count would produce a short first low phase after re-enable.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

  function automatic int cdf_width(input int gen);
    return (gen != 0) ? 3 : 2;
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CDF_W-1:0] cdf,
  output logic             tick
);
  logic [CDF_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == cdf) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_period_calc.sv
module scl_period_calc #(
  parameter int SCGD_W = 6,
  parameter int RW     = 8,
  parameter int PW     = 11
) (
  input  logic [SCGD_W-1:0] scgd,
  input  logic [RW-1:0]     comp,
  output logic [PW-1:0]     low_len,
  output logic [PW-1:0]     high_len
);
  localparam int BASE_TICKS = 20;
  logic [PW-1:0] period;

  always_comb begin
    period   = PW'(BASE_TICKS) + (PW'(scgd) << 3) + PW'(comp);
    low_len  = (period + 1'b1) >> 1;
    high_len = period >> 1;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_div_pkg::*;
#(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          scl_in,
  input  logic [PW-1:0] low_len,
  input  logic [PW-1:0] high_len,
  output logic          ph_low,
  output logic          ph_high,
  output logic          scl_low_o
);
  phase_t        state;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      ph_low    <= 1'b0;
      ph_high   <= 1'b0;
      scl_low_o <= 1'b0;
    end else begin
      ph_low  <= 1'b0;
      ph_high <= 1'b0;
      case (state)
        PH_IDLE: begin
          state     <= PH_LOW;
          cnt       <= '0;
          scl_low_o <= 1'b1;
          ph_low    <= 1'b1;
        end
        PH_LOW: begin
          if (tick) begin
            if (cnt == low_len - 1'b1) begin
              state     <= PH_HIGH;
              cnt       <= '0;
              scl_low_o <= 1'b0;
              ph_high   <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_HIGH: begin
          if (tick && scl_in) begin
            if (cnt == high_len - 1'b1) begin
              state     <= PH_LOW;
              cnt       <= '0;
              scl_low_o <= 1'b1;
              ph_low    <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int GEN    = 1,
  parameter int RW     = 8,
  parameter int SCGD_W = 6,
  localparam int CDF_W = scl_div_pkg::cdf_width(GEN),
  localparam int CFG_W = CDF_W + SCGD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [RW-1:0]    comp,
  input  logic             scl_in,
  output logic             tick,
  output logic             ph_low,
  output logic             ph_high,
  output logic             scl_low_o
);
  localparam int MAX_P = 20 + 8 * ((1 << SCGD_W) - 1) + (1 << RW);
  localparam int PW    = $clog2(MAX_P) + 1;

  logic [CDF_W-1:0]  cdf;
  logic [SCGD_W-1:0] scgd;
  logic [PW-1:0]     low_len;
  logic [PW-1:0]     high_len;

  assign cdf  = cfg_word[CDF_W-1:0];
  assign scgd = cfg_word[CFG_W-1:CDF_W];

  scl_prescaler #(.CDF_W(CDF_W)) u_pre (
    .clk(clk), .rst(rst), .en(en), .cdf(cdf), .tick(tick)
  );

  scl_period_calc #(.SCGD_W(SCGD_W), .RW(RW), .PW(PW)) u_calc (
    .scgd(scgd), .comp(comp), .low_len(low_len), .high_len(high_len)
  );

  scl_phase_seq #(.PW(PW)) u_seq (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .scl_in(scl_in),
    .low_len(low_len), .high_len(high_len),
    .ph_low(ph_low), .ph_high(ph_high), .scl_low_o(scl_low_o)
  );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
  parameter int CDF_W = 3,
  parameter int CFG_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CFG_W-1:0] cfg_word,
  input logic             scl_in,
  input logic             tick,
  input logic             ph_low,
  input logic             ph_high,
  input logic             scl_low_o
);
  logic [CDF_W:0] gap;
  logic           seen;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tick && !ph_low && !ph_high && !scl_low_o)); // R1

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && seen && en) |-> (gap == {1'b0, cfg_word[CDF_W-1:0]})); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ph_low && ph_high)); // R6

  AST_LOW_PULSE: assert property (@(posedge clk) disable iff (rst)
    ph_low |=> !ph_low); // R6

  AST_LOW_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ph_low |-> scl_low_o); // R6

  AST_HIGH_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ph_high |-> (!scl_low_o && $past(scl_low_o))); // R6

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !scl_low_o && !scl_in) |=> !scl_low_o); // R7
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.CDF_W(CDF_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cfg_word(cfg_word), .scl_in(scl_in),
  .tick(tick), .ph_low(ph_low), .ph_high(ph_high), .scl_low_o(scl_low_o)
);

// File: tb/scl_rate_gen_test.sv
`timescale 1ns/1ps
module scl_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [8:0] cfg_word = '0;
  logic [7:0] comp = '0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       tick, ph_low, ph_high, scl_low_o;

  logic       en2 = 1'b0;
  logic [7:0] cfg2 = '0;
  logic       scl2_in;
  logic       tick2, ph_low2, ph_high2, scl_low2;

  int n_chk = 0;
  int n_bad = 0;
  int overlap = 0;

  always #2 clk = ~clk;

  assign scl_in  = ~scl_low_o & ~hold;
  assign scl2_in = ~scl_low2;

  scl_rate_gen #(.GEN(1), .RW(8)) uut (
    .clk(clk), .rst(rst), .en(en), .cfg_word(cfg_word), .comp(comp),
    .scl_in(scl_in), .tick(tick), .ph_low(ph_low), .ph_high(ph_high),
    .scl_low_o(scl_low_o)
  );

  scl_rate_gen #(.GEN(0), .RW(8)) uut2 (
    .clk(clk), .rst(rst), .en(en2), .cfg_word(cfg2), .comp(comp),
    .scl_in(scl2_in), .tick(tick2), .ph_low(ph_low2), .ph_high(ph_high2),
    .scl_low_o(scl_low2)
  );

  always @(negedge clk) if (ph_low && ph_high) overlap++;

  function automatic int period_ticks(input int g, input int r);
    return 20 + 8 * g + r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input bit lvl, output int n);
    n = 0;
    while (scl_low_o == lvl && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_stretch(input int s, output int n);
    n = 0;
    hold = 1'b1;
    while (scl_low_o == 1'b0 && n < 20000) begin
      if (n == s) hold = 1'b0;
      n++;
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  task automatic tick_gap(output int n);
    n = 0;
    while (!tick && n < 100) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!tick && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic start(input int c, input int g, input int r);
    @(negedge clk);
    en = 1'b0;
    cfg_word = 9'((g << 3) | c);
    comp = 8'(r);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic full_check(input int c, input int g, input int r);
    int p, lo, hi, lo1, hi1, lo2, tg;
    p  = period_ticks(g, r);
    lo = (p + 1) / 2;
    hi = p / 2;
    start(c, g, r);
    chk(ph_low == 1'b1, "R6 ph_low on enable", int'(ph_low), 1);
    run_len(1'b1, lo1);
    chk(ph_high == 1'b1, "R6 ph_high at release", int'(ph_high), 1);
    run_len(1'b0, hi1);
    run_len(1'b1, lo2);
    chk(lo1 == lo * (c + 1), "R5 low run", lo1, lo * (c + 1));
    chk(hi1 == hi * (c + 1), "R5 high run", hi1, hi * (c + 1));
    chk(lo1 + hi1 == p * (c + 1), "R4 period", lo1 + hi1, p * (c + 1));
    chk(lo2 == lo * (c + 1), "R4 second low run", lo2, lo * (c + 1));
    tick_gap(tg);
    chk(tg == c + 1, "R2 tick spacing", tg, c + 1);
  endtask

  initial begin : watchdog
    #(4 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int n, lo, p;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(!tick && !ph_low && !ph_high && !scl_low_o, "R1 in reset",
        int'({tick, ph_low, ph_high, scl_low_o}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tick && !ph_low && !ph_high && !scl_low_o, "R1 disabled",
        int'({tick, ph_low, ph_high, scl_low_o}), 0);

    full_check(0, 0, 0);
    full_check(0, 0, 1);
    full_check(7, 1, 3);
    full_check(3, 2, 0);
    full_check(1, 0, 5);

    // R7 stretch, cdf 0
    start(0, 1, 2);
    p = period_ticks(1, 2);
    run_len(1'b1, n);
    run_stretch(7, n);
    chk(n == p / 2 + 7, "R7 stretched high c0", n, p / 2 + 7);
    // R7 stretch, cdf 1
    start(1, 0, 3);
    p = period_ticks(0, 3);
    run_len(1'b1, n);
    run_stretch(6, n);
    chk(n == (p / 2) * 2 + 6, "R7 stretched high c1", n, (p / 2) * 2 + 6);

    // R8 disable mid-period, re-enable
    start(2, 1, 1);
    p = period_ticks(1, 1);
    repeat (17) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!tick && !ph_low && !ph_high && !scl_low_o, "R8 disable releases",
        int'({tick, ph_low, ph_high, scl_low_o}), 0);
    en = 1'b1;
    @(negedge clk);
    run_len(1'b1, n);
    chk(n == ((p + 1) / 2) * 3, "R8 fresh low after re-enable", n, ((p + 1) / 2) * 3);
    en = 1'b0;

    // R3 narrow-field variant: cdf 3 in bits 1:0, scgd 2 from bit 2
    @(negedge clk);
    cfg2 = 8'((2 << 2) | 3);
    comp = 8'd4;
    en2 = 1'b1;
    @(negedge clk);
    n = 0;
    while (scl_low2 && n < 5000) begin
      n++;
      @(negedge clk);
    end
    lo = (period_ticks(2, 4) + 1) / 2;
    chk(n == lo * 4, "R3 narrow field low run", n, lo * 4);
    while (!tick2) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!tick2 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 4, "R3 narrow field tick spacing", n, 4);
    en2 = 1'b0;

    // random configurations
    for (int i = 0; i < 12; i++) begin
      full_check(int'($urandom_range(0, 7)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 31)));
    end

    chk(overlap == 0, "R6 strobes exclusive", overlap, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule